// File: doc/BRIEF.md
# Digit-Parallel GF(2^m) Multiplier

This block multiplies two elements of the binary field GF(2^163) held in polynomial basis. Operand B is cut into fixed-width digits, and every digit is multiplied carry-lessly by the full operand A in the same cycle. The partial products are shifted to their digit positions and XOR-combined into an unreduced product of 2m−1 bits. That product is then brought back to m bits by folding its upper half twice through the sparse tail of the field polynomial x^163 + x^7 + x^6 + x^3 + 1.

A caller presents both operands together with a one-cycle start strobe. The reduced product is registered once, and a done flag pulses in the following cycle. The registered result keeps its value until the next start. The field size, the digit width and the polynomial tail are parameters. The digit count and the width of the shorter last digit are derived from them, so the same code also serves wider fields such as m = 571.

Top module: `gf2m_dmul`

## Requirements
- R1: While reset is held and right after it, `result_o` is all zeros and `done_o` is 0.
- R2: `done_o` is 1 in exactly the cycle after a cycle with `start` high, and 0 after any cycle with `start` low.
- R3: While `start` is low, `result_o` keeps its last value whatever `a_i` and `b_i` do.
- R4: After a start, `result_o` equals A·B mod (x^163 + x^7 + x^6 + x^3 + 1), where bit i of each vector is the coefficient of x^i.
- R5: When either operand is zero, the result is zero.
- R6: When either operand is the element 1 (only bit 0 set), the result equals the other operand.
- R7: B is split into 41-bit digits with a final 40-bit digit (bits 123..162). Single-bit B values at the digit edges (bits 0, 40, 41, 122, 123, 162) give correctly reduced x^k·A.
- R8: Products whose degree reaches 2m−2, such as all-ones times all-ones, are fully reduced, including the second fold of the polynomial tail.
- R9: Starts on consecutive cycles produce each product in the cycle after its own start, with `done_o` held high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a multiply with the current operands |
| a_i | input | 163 | Operand A, polynomial basis |
| b_i | input | 163 | Operand B, polynomial basis, split into digits |
| result_o | output | 163 | Reduced product, held between starts |
| done_o | output | 1 | One-cycle flag marking a new result |

## Verification
All stimulus is compared against a bit-serial shift-and-add model that reduces after each shift. The model shares nothing with the digit-parallel structure, so any error in digit offsets or in the folding shows up as a mismatch.

The edge operands have distinct jobs. Zero and one check the neutral cases. Single-bit B values placed on each digit boundary expose a wrong digit width, a wrong offset or a dropped last digit. All-ones operands drive the product to its highest degree and exercise the second reduction fold. Random operand pairs cover general mixing.

Operand changes while `start` is low, and back-to-back starts, show that the result register loads only on a start and that each start yields its own product one cycle later.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
    localparam int FIELD_M_DEF   = 163;
    localparam int DIGIT_W_DEF   = 41;
    localparam int TAIL_W_DEF    = 8;
    localparam logic [7:0] POLY_TAIL_DEF = 8'hC9;

    function automatic int digit_count(input int m, input int dw);
        return (m + dw - 1) / dw;
    endfunction
endpackage

// File: rtl/gf2m_digit_mul.sv
// Carry-less product of one digit of B with the full operand A.
module gf2m_digit_mul #(
    parameter int M  = 163,
    parameter int DW = 41,
    localparam int PW = M + DW - 1
) (
    input  logic [M-1:0]  a_i,
    input  logic [DW-1:0] dig_i,
    output logic [PW-1:0] pp_o
);
    always_comb begin
        pp_o = '0;
        for (int j = 0; j < DW; j++) begin
            if (dig_i[j]) begin
                pp_o = pp_o ^ (PW'(a_i) << j);
            end
        end
    end
endmodule

// File: rtl/gf2m_reduce.sv
// Two-fold reduction by a sparse polynomial x^M + tail.
module gf2m_reduce #(
    parameter int M = 163,
    parameter int TAIL_W = 8,
    parameter logic [TAIL_W-1:0] POLY_TAIL = 8'hC9,
    localparam int PROD_W = 2*M - 1,
    localparam int T1_W   = M + TAIL_W - 2,
    localparam int C1_W   = TAIL_W - 2
) (
    input  logic [PROD_W-1:0] prod_i,
    output logic [M-1:0]      rem_o
);
    logic [M-2:0]  hi1;
    logic [T1_W-1:0] fold1;
    logic [C1_W-1:0] carry1;
    logic [M-1:0]  fold2;

    always_comb begin
        hi1   = prod_i[PROD_W-1:M];
        fold1 = '0;
        for (int k = 0; k < TAIL_W; k++) begin
            if (POLY_TAIL[k]) begin
                fold1 = fold1 ^ (T1_W'(hi1) << k);
            end
        end
        carry1 = fold1[T1_W-1:M];
        fold2  = '0;
        for (int k = 0; k < TAIL_W; k++) begin
            if (POLY_TAIL[k]) begin
                fold2 = fold2 ^ (M'(carry1) << k);
            end
        end
        rem_o = prod_i[M-1:0] ^ fold1[M-1:0] ^ fold2;
    end
endmodule

// File: rtl/gf2m_dmul.sv
module gf2m_dmul
    import gf2m_pkg::*;
#(
    parameter int M       = FIELD_M_DEF,
    parameter int DIGIT_W = DIGIT_W_DEF,
    parameter int TAIL_W  = TAIL_W_DEF,
    parameter logic [TAIL_W-1:0] POLY_TAIL = POLY_TAIL_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic [M-1:0] result_o,
    output logic         done_o
);
    localparam int NUM_DIG = digit_count(M, DIGIT_W);
    localparam int LAST_W  = M - (NUM_DIG - 1) * DIGIT_W;
    localparam int PROD_W  = 2*M - 1;

    typedef struct packed {
        logic [M-1:0] res;
        logic         done;
    } state_t;

    state_t state_d, state_q;
    logic [PROD_W-1:0] placed [NUM_DIG];
    logic [PROD_W-1:0] prod;
    logic [M-1:0]      reduced;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        localparam int DW_G = (g == NUM_DIG - 1) ? LAST_W : DIGIT_W;
        localparam int OFF  = g * DIGIT_W;
        logic [M+DW_G-2:0] pp;
        gf2m_digit_mul #(.M(M), .DW(DW_G)) u_dig (
            .a_i  (a_i),
            .dig_i(b_i[OFF +: DW_G]),
            .pp_o (pp)
        );
        assign placed[g] = PROD_W'(pp) << OFF;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < NUM_DIG; i++) begin
            prod = prod ^ placed[i];
        end
    end

    gf2m_reduce #(.M(M), .TAIL_W(TAIL_W), .POLY_TAIL(POLY_TAIL)) u_red (
        .prod_i(prod),
        .rem_o (reduced)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start;
        if (start) begin
            state_d.res = reduced;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign done_o   = state_q.done;
endmodule

// File: rtl/gf2m_dmul_chk.sv
module gf2m_dmul_chk #(
    parameter int M = 163
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [M-1:0] a_i,
    input logic [M-1:0] b_i,
    input logic [M-1:0] result_o,
    input logic         done_o
);
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done_o);
    p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done_o);
    p_hold_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result_o));
    p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (a_i == '0 || b_i == '0)) |=> (result_o == '0));
    p_unit_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && b_i == M'(1)) |=> (result_o == $past(a_i)));
endmodule

bind gf2m_dmul gf2m_dmul_chk #(.M(M)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .done_o(done_o)
);

// File: tb/gf2m_dmul_tb.sv
module gf2m_dmul_tb;
    localparam int CLK_PERIOD = 10;
    localparam int M = 163;
    localparam logic [M:0] POLY_FULL = {1'b1, 155'b0, 8'hC9};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic [M-1:0] result_o;
    logic         done_o;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gf2m_dmul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_i(a_in), .b_i(b_in),
        .result_o(result_o), .done_o(done_o)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M:0] r = '0;
        for (int i = M-1; i >= 0; i--) begin
            r = r << 1;
            if (r[M]) r = r ^ POLY_FULL;
            if (b[i]) r = r ^ {1'b0, a};
        end
        return r[M-1:0];
    endfunction

    function automatic logic [M-1:0] rand_elem();
        logic [191:0] t = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return t[M-1:0];
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One multiply: start at negedge, sample one cycle later.
    task automatic run_mul(input string req, input logic [M-1:0] a, input logic [M-1:0] b);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " done"}, M'(done_o), M'(1));
        check(req, result_o, ref_mul(a, b));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 result", result_o, '0);
        check("R1 done", M'(done_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after release", result_o, '0);
        check("R1 done after release", M'(done_o), '0);
    endtask

    task automatic t_zero_one();
        logic [M-1:0] r = rand_elem();
        run_mul("R5 a=0", '0, r);
        run_mul("R5 b=0", r, '0);
        run_mul("R6 b=1", r, M'(1));
        run_mul("R6 a=1", M'(1), r);
    endtask

    task automatic t_digit_edges();
        int pos [6] = '{0, 40, 41, 122, 123, 162};
        logic [M-1:0] a = rand_elem();
        foreach (pos[i]) begin
            run_mul($sformatf("R7 b=x^%0d", pos[i]), a, M'(1) << pos[i]);
        end
        run_mul("R7 last digit full", a, {40'hFF_FFFF_FFFF, 123'b0});
    endtask

    task automatic t_all_ones();
        run_mul("R8 ones x ones", '1, '1);
        run_mul("R8 ones x x^162", '1, M'(1) << 162);
    endtask

    task automatic t_random();
        for (int n = 0; n < 40; n++) begin
            run_mul("R4 random", rand_elem(), rand_elem());
        end
    endtask

    task automatic t_hold();
        logic [M-1:0] a = rand_elem();
        logic [M-1:0] b = rand_elem();
        logic [M-1:0] exp = ref_mul(a, b);
        run_mul("R4 before hold", a, b);
        a_in = rand_elem(); b_in = rand_elem();
        @(negedge clk);
        check("R2 done low when idle", M'(done_o), '0);
        check("R3 held with new operands", result_o, exp);
        a_in = '1; b_in = '1;
        @(negedge clk);
        check("R3 still held", result_o, exp);
    endtask

    task automatic t_back_to_back();
        logic [M-1:0] a [3];
        logic [M-1:0] b [3];
        for (int i = 0; i < 3; i++) begin a[i] = rand_elem(); b[i] = rand_elem(); end
        @(negedge clk);
        a_in = a[0]; b_in = b[0]; start = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 done", M'(done_o), M'(1));
            check("R9 result", result_o, ref_mul(a[i], b[i]));
            if (i < 2) begin a_in = a[i+1]; b_in = b[i+1]; end
            else start = 1'b0;
        end
        @(negedge clk);
        check("R2 done drops", M'(done_o), '0);
    endtask

    initial begin
        t_reset();
        t_zero_one();
        t_digit_edges();
        t_all_ones();
        t_random();
        t_hold();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule